// File: doc/BRIEF.md
# Four-Channel Polynomial Noise and Tone Generator

This block makes sound for four channels from one system clock. Each channel has an 8-bit down-counting divider and an 8-bit control byte. The control byte selects a 4-bit volume, a volume-only override and one of eight distortion settings. At each divider underflow the channel either toggles a square wave or samples one of three free-running shift-register noise sources. It can also be gated by the 5-bit source, which lets it change only when that source is high. Each channel presents a 4-bit level code, and an external mixer sums the four codes.

A global mode byte controls the shared features. It picks the base rate for all dividers: one tick every 28 or every 114 system clocks. It can clock channels 1 and 3 at the full system rate. It can chain dividers 1→2 and 3→4 into 16-bit counters. It can place an XOR/flip-flop high-pass stage in channel 1 or channel 2, and it can shorten the long noise source from 17 to 9 bits. A restart strobe reloads every divider. Three dividers emit timer pulses, and the top byte of the long noise source is readable as a random byte.

Top module: `noise_tone_gen`

## Requirements
- R1: A divider loaded with F underflows every F+1 of its ticks. In pure-tone mode (control bits 7..5 = 101 or 111) the channel level therefore changes every F+1 ticks. At full rate (mode bit 6 for channel 1, bit 5 for channel 3) one tick is one clock.
- R2: Dividers without a faster source tick once every 28 clocks when mode bit 0 = 0, and once every 114 clocks when mode bit 0 = 1.
- R3: Mode bit 4 chains divider 2 onto divider 1, and mode bit 3 chains divider 4 onto divider 3. The even channel is the high byte, and the 16-bit value F underflows every F+1 ticks. While chained, the odd channel's level is 0 unless its volume-only bit is set.
- R4: At underflow, control bits 7..5 decide the next channel signal. Bit 7 = 0 allows a change only when the 5-bit source (period 31) is 1. Bit 5 = 1 toggles the signal. Otherwise bit 6 = 1 takes the 4-bit source (period 15), and bit 6 = 0 takes the long source. The long source has period 511 when mode bit 7 = 1 and is 17 bits long otherwise.
- R5: When control bit 4 = 1, the level equals control bits 3..0, whatever the divider, noise and filter are doing.
- R6: When control bit 4 = 0 and the channel signal is low, the level is 0. When the signal is high, the level equals the volume.
- R7: Mode bit 2 XORs channel 1's signal with a flip-flop copy of it that is sampled at divider 3 underflow. Mode bit 1 does the same for channel 2, with the copy sampled at divider 4 underflow.
- R8: The restart strobe reloads all dividers, sets the signals of channels 1 and 2 high, and clears those of channels 3 and 4.
- R9: Underflows of dividers 1, 2 and 4 appear as one-clock pulses on timer bits 0, 1 and 2.
- R10: The random byte is the top 8 bits of the long source. It reads 0xFF while reset is held, and it changes once reset is released.
- R11: Register writes use addresses 2c (frequency) and 2c+1 (control) for channel c = 0..3, and address 8 for the mode byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (the full rate) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| restart | input | 1 | Reload all dividers and preset the channel signals |
| level_o | output | 16 | Four 4-bit level codes, channel c at bits 4c+3..4c |
| timer_o | output | 3 | Timer pulses from dividers 1, 2 and 4 |
| rand_o | output | 8 | Random byte |

## Verification
The assertions check these properties on every cycle: the volume-only override, the preset values after a restart, the muting of a chained odd channel, the reload value after an unchained underflow, and that no noise register ever sits at zero. The bench scenarios cover what needs long windows of observation. They measure tone periods at each clock base and in the 16-bit chain, and they check the period and density of ones of each noise source. They also check the duty cycle that the high-pass stage produces and count timer pulses.

// File: rtl/ntg_pkg.sv
package ntg_pkg;
  localparam int NCH = 4;
  localparam int LVW = 4;

  // next channel signal at an underflow; sel = control bits 7..5
  function automatic logic chan_next(input logic [2:0] sel, input logic cur,
                                     input logic p5, input logic p4, input logic pl);
    if (!sel[2] && !p5) return cur;
    if (sel[0]) return ~cur;
    if (sel[1]) return p4;
    return pl;
  endfunction
endpackage

// File: rtl/ntg_prescale.sv
module ntg_prescale #(
  parameter int DIV_A = 28,
  parameter int DIV_B = 114
) (
  input  logic clk,
  input  logic rst,
  output logic tick_a,
  output logic tick_b
);
  logic [1:0] tk;
  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_pre
      localparam int D  = (g == 0) ? DIV_A : DIV_B;
      localparam int CW = $clog2(D);
      logic [CW-1:0] cnt;
      assign tk[g] = (cnt == CW'(D - 1));
      always_ff @(posedge clk) begin
        if (rst || tk[g]) cnt <= '0;
        else              cnt <= cnt + 1'b1;
      end
    end
  endgenerate
  assign tick_a = tk[0];
  assign tick_b = tk[1];
endmodule

// File: rtl/ntg_poly.sv
module ntg_poly #(
  parameter int LONG = 17,
  parameter int SHORT = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       short_mode,
  output logic       p5,
  output logic       p4,
  output logic       pl,
  output logic [7:0] rand_byte
);
  logic [LONG-1:0]  ql;
  logic [4:0]       q5;
  logic [3:0]       q4;
  logic             fb_long, fb_short;

  assign fb_long  = (ql[LONG-1] ^ ql[13]) | (ql == '0);
  assign fb_short = (ql[SHORT-1] ^ ql[4]) | (ql[SHORT-1:0] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ql <= '1;
      q5 <= '1;
      q4 <= '1;
    end else begin
      q5 <= {q5[3:0], q5[4] ^ q5[2]};
      q4 <= {q4[2:0], q4[3] ^ q4[2]};
      if (short_mode) ql[SHORT-1:0] <= {ql[SHORT-2:0], fb_short};
      else            ql <= {ql[LONG-2:0], fb_long};
    end
  end

  assign p5 = q5[4];
  assign p4 = q4[3];
  assign pl = short_mode ? ql[SHORT-1] : ql[LONG-1];
  assign rand_byte = short_mode ? ql[SHORT-1:SHORT-8] : ql[LONG-1:LONG-8];

  // R4 R10: no noise register ever holds all zeros
  poly_live_chk: assert property (@(posedge clk) disable iff (rst)
    (q5 != '0) && (q4 != '0) && (short_mode ? (ql[SHORT-1:0] != '0) : (ql != '0)));
endmodule

// File: rtl/ntg_pair_div.sv
module ntg_pair_div #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         paired,
  input  logic         tick_lo,
  input  logic         tick_hi,
  input  logic [W-1:0] f_lo,
  input  logic [W-1:0] f_hi,
  output logic         uf_lo,
  output logic         uf_hi
);
  logic [W-1:0] lo, hi, lo_reload;
  logic         hi_tick;

  assign uf_lo     = tick_lo && (lo == '0);
  assign hi_tick   = paired ? uf_lo : tick_hi;
  assign uf_hi     = hi_tick && (hi == '0);
  assign lo_reload = (paired && (hi != '0)) ? {W{1'b1}} : f_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo <= '0;
      hi <= '0;
    end else if (restart) begin
      lo <= f_lo;
      hi <= f_hi;
    end else begin
      if (uf_lo)        lo <= lo_reload;
      else if (tick_lo) lo <= lo - 1'b1;
      if (uf_hi)        hi <= f_hi;
      else if (hi_tick) hi <= hi - 1'b1;
    end
  end

  // R1: an unchained underflow reloads the register value
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (uf_lo && !restart && !paired) |=> (lo == $past(f_lo)));
  // R3: the high byte only moves on a low-byte underflow while chained
  chain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (paired && !uf_lo && !restart) |=> (hi == $past(hi)));
endmodule

// File: rtl/noise_tone_gen.sv
module noise_tone_gen
  import ntg_pkg::*;
#(
  parameter int FW     = 8,
  parameter int DIV_64 = 28,
  parameter int DIV_15 = 114
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              restart,
  output logic [NCH*LVW-1:0] level_o,
  output logic [2:0]        timer_o,
  output logic [7:0]        rand_o
);
  logic [FW-1:0] freq [NCH];
  logic [7:0]    ctrl [NCH];
  logic [7:0]    mode;
  logic [NCH-1:0] tick, uf, sq, outs, mute;
  logic [1:0]     hp;
  logic t64, t15, base, p5, p4, pl;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= '0;
      for (int c = 0; c < NCH; c++) begin
        freq[c] <= '0;
        ctrl[c] <= '0;
      end
    end else if (wr_en) begin
      if (wr_addr == 4'd8) mode <= wr_data;
      else if (!wr_addr[3]) begin
        if (wr_addr[0]) ctrl[wr_addr[2:1]] <= wr_data;
        else            freq[wr_addr[2:1]] <= wr_data[FW-1:0];
      end
    end
  end

  ntg_prescale #(.DIV_A(DIV_64), .DIV_B(DIV_15)) u_pre (
    .clk(clk), .rst(rst), .tick_a(t64), .tick_b(t15));

  ntg_poly u_poly (
    .clk(clk), .rst(rst), .short_mode(mode[7]),
    .p5(p5), .p4(p4), .pl(pl), .rand_byte(rand_o));

  assign base    = mode[0] ? t15 : t64;
  assign tick[0] = mode[6] | base;
  assign tick[1] = base;
  assign tick[2] = mode[5] | base;
  assign tick[3] = base;
  assign mute[0] = mode[4];
  assign mute[1] = 1'b0;
  assign mute[2] = mode[3];
  assign mute[3] = 1'b0;

  genvar p, c, j;
  generate
    for (p = 0; p < 2; p++) begin : g_pair
      ntg_pair_div #(.W(FW)) u_div (
        .clk(clk), .rst(rst), .restart(restart),
        .paired(mode[4 - p]),
        .tick_lo(tick[2*p]), .tick_hi(tick[2*p+1]),
        .f_lo(freq[2*p]), .f_hi(freq[2*p+1]),
        .uf_lo(uf[2*p]), .uf_hi(uf[2*p+1]));
    end

    for (j = 0; j < 2; j++) begin : g_hp
      always_ff @(posedge clk) begin
        if (rst)             hp[j] <= 1'b0;
        else if (uf[j + 2])  hp[j] <= sq[j];
      end
      assign outs[j] = mode[2 - j] ? (sq[j] ^ hp[j]) : sq[j];
    end
    assign outs[3:2] = sq[3:2];

    for (c = 0; c < NCH; c++) begin : g_ch
      logic [LVW-1:0] lvl;
      always_ff @(posedge clk) begin
        if (rst)          sq[c] <= 1'b0;
        else if (restart) sq[c] <= (c < 2);
        else if (uf[c])   sq[c] <= chan_next(ctrl[c][7:5], sq[c], p5, p4, pl);
      end
      always_ff @(posedge clk) begin
        if (rst)                lvl <= '0;
        else if (ctrl[c][4])    lvl <= ctrl[c][3:0];
        else if (mute[c])       lvl <= '0;
        else                    lvl <= outs[c] ? ctrl[c][3:0] : '0;
      end
      assign level_o[c*LVW +: LVW] = lvl;

      // R5: volume-only override
      vol_only_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl[c][4] |=> (lvl == $past(ctrl[c][3:0])));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) timer_o <= '0;
    else     timer_o <= {uf[3], uf[1], uf[0]};
  end

  // R8: restart presets the channel signals
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (sq == 4'b0011));
  // R3: a chained odd channel is silent unless volume-only
  mute_chk: assert property (@(posedge clk) disable iff (rst)
    (mode[4] && !ctrl[0][4]) |=> (level_o[3:0] == '0));
endmodule

// File: tb/noise_tone_gen_tb.sv
module noise_tone_gen_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic restart = 1'b0;
  logic [15:0] level_o;
  logic [2:0] timer_o;
  logic [7:0] rand_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  noise_tone_gen dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .restart(restart), .level_o(level_o), .timer_o(timer_o), .rand_o(rand_o));

  function automatic logic [3:0] lvl(input int ch);
    return level_o[ch*4 +: 4];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_restart();
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  // cycles until level of ch changes
  task automatic gap(input int ch, input int lim, output int n);
    logic [3:0] s;
    s = lvl(ch);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (lvl(ch) == s && n < lim);
  endtask

  task automatic t_reset();
    int changes = 0;
    logic [7:0] prev;
    repeat (3) @(negedge clk);
    check("R10 rand during reset", rand_o, 8'hFF);
    check("R6 level at reset", level_o, 0);
    check("R9 timer at reset", timer_o, 0);
    rst = 1'b0;
    prev = rand_o;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (rand_o != prev) changes++;
      prev = rand_o;
    end
    check("R10 rand moves", (changes > 0) ? 1 : 0, 1);
  endtask

  task automatic t_tone();
    int n;
    wr(4'd8, 8'h40); wr(4'd0, 8'd5); wr(4'd1, 8'hA9);
    do_restart();
    gap(0, 50, n);
    gap(0, 50, n);
    check("R1 tone half period", n, 6);
    gap(0, 50, n);
    check("R1 tone half period again", n, 6);
    check("R6 level is 0 or volume", (lvl(0) == 0 || lvl(0) == 9) ? 1 : 0, 1);
  endtask

  task automatic t_base();
    int n;
    wr(4'd8, 8'h00); wr(4'd4, 8'd0); wr(4'd5, 8'hA4);
    gap(2, 300, n); gap(2, 300, n);
    check("R2 64k base interval", n, 28);
    wr(4'd8, 8'h01);
    gap(2, 300, n); gap(2, 300, n);
    check("R2 15k base interval", n, 114);
  endtask

  task automatic t_restart();
    wr(4'd8, 8'h40);
    wr(4'd0, 8'd5);   wr(4'd1, 8'hA9);
    wr(4'd2, 8'hFF);  wr(4'd3, 8'hA7);
    wr(4'd4, 8'hFF);  wr(4'd5, 8'hA3);
    wr(4'd6, 8'hFF);  wr(4'd7, 8'hAA);
    do_restart();
    @(negedge clk);
    check("R8 ch1 high after restart", lvl(0), 9);
    check("R8 ch2 high after restart", lvl(1), 7);
    check("R8 ch3 low after restart", lvl(2), 0);
    check("R6 ch4 low input gives 0", lvl(3), 0);
    wr(4'd7, 8'h1A);
    @(negedge clk);
    check("R5 volume only", lvl(3), 10);
  endtask

  task automatic t_timer();
    int cnt = 0;
    wr(4'd8, 8'h40); wr(4'd0, 8'd3);
    do_restart();
    repeat (8) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (timer_o[0]) cnt++;
    end
    check("R9 timer1 pulse count", cnt, 10);
  endtask

  task automatic t_pair();
    int n, cnt = 0, nz = 0;
    wr(4'd8, 8'h50); wr(4'd0, 8'd3); wr(4'd2, 8'd1);
    wr(4'd1, 8'hA9); wr(4'd3, 8'hA5);
    do_restart();
    gap(1, 600, n);
    gap(1, 600, n);
    check("R3 16-bit half period", n, 260);
    for (int i = 0; i < 520; i++) begin
      @(negedge clk);
      if (timer_o[1]) cnt++;
      if (lvl(0) != 0) nz++;
    end
    check("R9 timer2 pulses in chain", cnt, 2);
    check("R3 low channel muted", nz, 0);
  endtask

  task automatic t_noise();
    logic s [0:1100];
    int ones = 0, ch = 0, mis = 0;
    wr(4'd8, 8'h40); wr(4'd0, 8'd0); wr(4'd1, 8'hCF);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 30; i++) begin @(negedge clk); s[i] = (lvl(0) != 0); end
    for (int i = 0; i < 15; i++) begin
      if (s[i]) ones++;
      if (s[i] != s[i+15]) mis++;
    end
    check("R4 4-bit source period 15", mis, 0);
    check("R4 4-bit source ones", ones, 8);
    wr(4'd1, 8'h2F);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 32; i++) begin @(negedge clk); s[i] = (lvl(0) != 0); end
    for (int i = 1; i < 32; i++) if (s[i] != s[i-1]) ch++;
    check("R4 5-bit gated toggles", ch, 16);
    wr(4'd8, 8'hC0); wr(4'd1, 8'h8F);
    repeat (4) @(negedge clk);
    ones = 0; mis = 0;
    for (int i = 0; i < 1022; i++) begin @(negedge clk); s[i] = (lvl(0) != 0); end
    for (int i = 0; i < 511; i++) begin
      if (s[i]) ones++;
      if (s[i] != s[i+511]) mis++;
    end
    check("R4 9-bit source ones", ones, 256);
    check("R4 9-bit source period 511", mis, 0);
    wr(4'd8, 8'h40);
    repeat (4) @(negedge clk);
    mis = 0;
    for (int i = 0; i < 1022; i++) begin @(negedge clk); s[i] = (lvl(0) != 0); end
    for (int i = 0; i < 511; i++) if (s[i] != s[i+511]) mis++;
    check("R4 17-bit source not period 511", (mis > 0) ? 1 : 0, 1);
  endtask

  task automatic t_hpf();
    int nz = 0;
    wr(4'd8, 8'h64); wr(4'd0, 8'd9); wr(4'd4, 8'd0); wr(4'd1, 8'hAC);
    do_restart();
    repeat (20) @(negedge clk);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (lvl(0) != 0) nz++;
    end
    check("R7 high-pass duty", nz, 10);
  endtask

  task automatic t_regmap();
    wr(4'd8, 8'h00);
    wr(4'd9, 8'hFF);
    wr(4'd3, 8'h15);
    @(negedge clk);
    check("R11 control address of channel 2", lvl(1), 5);
  endtask

  initial begin
    t_reset();
    t_tone();
    t_base();
    t_restart();
    t_timer();
    t_pair();
    t_noise();
    t_hpf();
    t_regmap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule